// File: doc/BRIEF.md
# Bidirectional Port with Alternate-Function Output Priority

This block controls an eight-pin bidirectional port. Software reaches it through a small synchronous register bus. The bus has an address, a write strobe, write data and combinational read data. There are three registers:

- an output latch,
- a read-only pin-sample view,
- a per-pin direction mask.

Each pin's pad driver receives a value and an output enable. These come from whichever source owns the pin. The LCD segment driver has the highest rank, the PWM channel comes next, and the output latch comes last. The LCD and PWM sources connect only as per-pin enable and value vectors.

Pad inputs pass through a two-stage synchronizer before any read path sees them. The pin-sample view always shows the synchronized pins. Software can compare that view with what it drives and so find a pin held against its driver, such as an overload or a short. Reading the output latch location mixes two sources per bit. Output pins return the stored bit. Input pins return the synchronized pin.

Top module: `gpio_port_arb`

## Requirements
- R1: After reset, every direction bit is 0 and the output latch is 0. With no alternate source enabled, `pad_oe` is 0 on all pins.
- R2: A write to offset 0 stores the output latch. Reading offset 0 returns the stored bit on each pin whose direction bit is 1.
- R3: Reading offset 0 returns the synchronized pin level on each pin whose direction bit is 0.
- R4: On a pin whose `lcd_en` bit is 1, `pad_out` equals `lcd_val` and `pad_oe` is 1, whatever PWM and latch settings are present.
- R5: On a pin whose `lcd_en` bit is 0 and `pwm_en` bit is 1, `pad_out` equals `pwm_val` and `pad_oe` is 1.
- R6: On a pin with neither alternate source enabled, `pad_out` equals the output latch bit and `pad_oe` equals the direction bit.
- R7: Reading offset 1 returns the synchronized pin levels, whatever the direction and alternate-source settings.
- R8: A write to offset 1 changes no register. The latch, direction and pin-sample values read back as before.
- R9: A change on `pad_in` shows on the read paths after the second rising clock edge, not after the first.
- R10: Offset 2 holds the direction mask: written by a bus write and returned on read, with bit value 1 meaning output. Offset 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| lcd_en | input | 8 | Per-pin LCD segment ownership |
| lcd_val | input | 8 | Per-pin LCD segment level |
| pwm_en | input | 8 | Per-pin PWM channel ownership |
| pwm_val | input | 8 | Per-pin PWM level |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Value to pad drivers |
| pad_oe | output | 8 | Output enable to pad drivers |

## Verification
The hardest case to reach from the ports is a per-bit mix where every pin is decided differently. In that case some pins are owned by the LCD, some by PWM, and the rest by the latch, with direction bits that disagree with ownership. A second hard case is a latch read that blends stored bits with synchronized pins.

The stimulus table sets overlapping LCD and PWM enable masks over a direction mask that conflicts with them. Each pin therefore lands in a different branch of the priority. Directed steps hold a pin pattern that differs from the latch contents. They then read the latch across both synchronizer edges, which shows the blend and the two-edge latency.

// File: rtl/gpio_port_arb.sv
module gpio_port_arb #(
  parameter int WIDTH    = 8,
  parameter int AW       = 2,
  parameter int DATA_OFS = 0,
  parameter int IN_OFS   = 1,
  parameter int DIR_OFS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] lcd_en,
  input  logic [WIDTH-1:0] lcd_val,
  input  logic [WIDTH-1:0] pwm_en,
  input  logic [WIDTH-1:0] pwm_val,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);

  logic [WIDTH-1:0] latch_q, dir_q, meta_q, pin_q;

  // Pin sampling is deliberately outside reset: it only mirrors the pads.
  always_ff @(posedge clk) begin
    meta_q <= pad_in;
    pin_q  <= meta_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else if (bus_we) begin
      if (bus_addr == AW'(DATA_OFS)) latch_q <= bus_wdata;
      if (bus_addr == AW'(DIR_OFS))  dir_q   <= bus_wdata;
    end
  end

  always_comb begin
    if (bus_addr == AW'(DATA_OFS))     bus_rdata = (latch_q & dir_q) | (pin_q & ~dir_q);
    else if (bus_addr == AW'(IN_OFS))  bus_rdata = pin_q;
    else if (bus_addr == AW'(DIR_OFS)) bus_rdata = dir_q;
    else                               bus_rdata = '0;
  end

  assign pad_out = (lcd_en & lcd_val) | (~lcd_en & pwm_en & pwm_val) | (~lcd_en & ~pwm_en & latch_q);
  assign pad_oe  = lcd_en | pwm_en | dir_q;

endmodule

// File: rtl/gpio_port_arb_chk.sv
module gpio_port_arb_chk #(
  parameter int WIDTH   = 8,
  parameter int AW      = 2,
  parameter int IN_OFS  = 1,
  parameter int DIR_OFS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] lcd_en,
  input logic [WIDTH-1:0] lcd_val,
  input logic [WIDTH-1:0] pwm_en,
  input logic [WIDTH-1:0] pwm_val,
  input logic [WIDTH-1:0] pad_in,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] dir_q
);

  p_lcd_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ lcd_val) & lcd_en) == '0);

  p_pwm_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ pwm_val) & pwm_en & ~lcd_en) == '0);

  p_alt_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((lcd_en | pwm_en) & ~pad_oe) == '0);

  p_dir_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(DIR_OFS)) |=>
      ((pad_oe & ~(lcd_en | pwm_en)) == ($past(bus_wdata) & ~(lcd_en | pwm_en))));

  p_in_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(IN_OFS)) |=> $stable(dir_q));

  p_sync_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(IN_OFS)) |-> (bus_rdata == $past(pad_in, 2)));

endmodule

bind gpio_port_arb gpio_port_arb_chk #(
  .WIDTH(WIDTH), .AW(AW), .IN_OFS(IN_OFS), .DIR_OFS(DIR_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lcd_en(lcd_en),
  .lcd_val(lcd_val), .pwm_en(pwm_en), .pwm_val(pwm_val), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .dir_q(dir_q)
);

// File: tb/gpio_port_arb_bench.sv
module gpio_port_arb_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [7:0] lcd_en = 0, lcd_val = 0, pwm_en = 0, pwm_val = 0, pad_in = 0;
  logic [7:0] pad_out, pad_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_port_arb u_gpio_port_arb (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lcd_en(lcd_en),
    .lcd_val(lcd_val), .pwm_en(pwm_en), .pwm_val(pwm_val), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // dir, latch, lcd_en, lcd_val, pwm_en, pwm_val, exp_out, exp_oe
  localparam logic [63:0] VEC [6] = '{
    {8'hFF, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 8'hA5, 8'hFF},
    {8'h00, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h00, 8'h3C, 8'h00},
    {8'h00, 8'h00, 8'hFF, 8'h5A, 8'hFF, 8'hA5, 8'h5A, 8'hFF},
    {8'h0F, 8'hFF, 8'h00, 8'h00, 8'hF0, 8'h30, 8'h3F, 8'hFF},
    {8'h00, 8'hFF, 8'h0F, 8'h05, 8'h3C, 8'h28, 8'hE5, 8'h3F},
    {8'h81, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 8'h81}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(2'd2, r); chk("R1 dir reset", r, 8'h00);
    chk("R1 oe reset", pad_oe, 8'h00);
    chk("R1 latch reset", pad_out, 8'h00);

    foreach (VEC[i]) begin
      wr(2'd2, VEC[i][63:56]);
      wr(2'd0, VEC[i][55:48]);
      lcd_en = VEC[i][47:40]; lcd_val = VEC[i][39:32];
      pwm_en = VEC[i][31:24]; pwm_val = VEC[i][23:16];
      #1;
      chk("R4 R5 R6 pad_out", pad_out, VEC[i][15:8]);
      chk("R4 R5 R6 pad_oe", pad_oe, VEC[i][7:0]);
    end
    lcd_en = 0; pwm_en = 0;

    // R2 / R10: full output readback
    wr(2'd2, 8'hFF); wr(2'd0, 8'h69);
    rd(2'd0, r); chk("R2 latch read", r, 8'h69);
    rd(2'd2, r); chk("R10 dir read", r, 8'hFF);
    rd(2'd3, r); chk("R10 unused offset", r, 8'h00);

    // R9: two-edge latency on pin sampling
    @(negedge clk); pad_in = 8'hC3;
    rd(2'd1, r); chk("R9 before edges", r, 8'h00);
    @(negedge clk); rd(2'd1, r); chk("R9 after one edge", r, 8'h00);
    @(negedge clk); rd(2'd1, r); chk("R9 after two edges", r, 8'hC3);

    // R3: blended latch read
    wr(2'd2, 8'h0F); wr(2'd0, 8'h55);
    rd(2'd0, r); chk("R3 blended read", r, 8'hC5);

    // R7: pin view ignores direction and alternates
    lcd_en = 8'hFF; lcd_val = 8'h00; pwm_en = 8'hFF;
    rd(2'd1, r); chk("R7 pin view", r, 8'hC3);
    lcd_en = 0; pwm_en = 0;

    // R8: write to pin view has no effect
    wr(2'd1, 8'h3C);
    rd(2'd1, r); chk("R8 pin view kept", r, 8'hC3);
    rd(2'd2, r); chk("R8 dir kept", r, 8'h0F);
    rd(2'd0, r); chk("R8 latch kept", r, 8'hC5);
    #1 chk("R8 pad_out kept", pad_out, 8'h55);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule